// File: doc/BRIEF.md
# Fuse Shadow Register File

This block keeps a bus-readable copy of every word of a one-time-programmable fuse array. Software reaches the copies through a memory-mapped window. Word `i` sits at byte offset `0x400 + 0x10*i`, and the default size is 128 words. Each word carries a read lock and a write lock, supplied as per-word input vectors. A control register and two alias addresses let software start a refresh of every shadow from the fuse array and clear a sticky error flag.

A refresh visits the fuse words in ascending order and spends a fixed number of cycles on each one. `busy` stays high for the whole refresh. Illegal accesses set the error flag. These are a write while a refresh runs, a write to a write-locked word, and a read of a read-locked word. A read of a read-locked word also returns the marker `0xBADABADA`. While the flag is set, the block accepts no shadow read, no shadow write and no refresh start. The control addresses stay usable, so software can see the flag and clear it.

Top module: `fsr_shadow_file`

## Requirements
- R1: After reset, `busy` and `error` are 0, every shadow word reads 0, and the control register reads 0.
- R2: A write to byte offset `0x400 + 0x10*i` (for `i` below the word count) stores the data in word `i`, and a read there returns it. A read at a misaligned offset or beyond the last word returns 0, and a write there changes nothing.
- R3: A read presented with `bus_req` high and `bus_we` low is answered on the next clock edge, with `bus_rvalid` high for one cycle.
- R4: Writing 1 to bit 0 of the set alias (offset `0x004`) starts a refresh. `busy` and control bits 0 and 2 then stay high for exactly `NUM_WORDS*WORD_CYCLES` cycles. `fuse_rd` is high and `fuse_addr` holds word `k` during cycles `k*WORD_CYCLES` to `(k+1)*WORD_CYCLES-1` of the refresh.
- R5: After a refresh, every shadow word equals the fuse word at the same index. This includes write-locked words.
- R6: A shadow write accepted while `busy` is high sets `error` and leaves the word unchanged. This holds in the last cycle of the refresh as well.
- R7: A write to a word whose `wr_lock` bit is set sets `error` and leaves the word unchanged.
- R8: A read of a word whose `rd_lock` bit is set returns `0xBADABADA` and sets `error`.
- R9: While `error` is set, shadow reads return 0, shadow writes are dropped, and a refresh start is ignored. Reads of the control register (offset `0x000`) still return bit 0 refresh, bit 1 error and bit 2 busy.
- R10: Writing 1 to bit 1 of the set alias sets `error`, and writing 1 to bit 1 of the clear alias (offset `0x008`) clears it. A 0 bit leaves the flag as it is. A clear of bit 0 does not stop a refresh, and writes to offset `0x000` have no effect.
- R11: A single set-alias write carrying both bit 0 and bit 1 sets `error` and does not start a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer strobe |
| rd_lock | input | NUM_WORDS | Per-word read lock |
| wr_lock | input | NUM_WORDS | Per-word write lock |
| fuse_addr | output | IDX_W | Fuse word being fetched |
| fuse_rd | output | 1 | Fuse fetch active |
| fuse_data | input | 32 | Fuse word at fuse_addr |
| busy | output | 1 | Refresh in progress |
| error | output | 1 | Sticky access error flag |

## Verification
A shadow write can land in the same cycle as the refresh's final capture. In that cycle the sequencer is still busy but is about to drop `busy`. The bench counts busy cycles from the start of a refresh and issues a write to an already captured word exactly on the last one. It judges the outcome by `error` rising and by the word still holding its fuse value when read back afterwards. Other accesses are placed inside the refresh: an error clear, a clear of bit 0 and a control read. These confirm that none of them disturbs the capture order or the exact refresh length.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int WORD_W = 32;
    localparam int CTRL_RELOAD_BIT = 0;
    localparam int CTRL_ERROR_BIT  = 1;
    localparam int CTRL_BUSY_BIT   = 2;
    localparam logic [WORD_W-1:0] LOCKED_MARKER = 32'hBADA_BADA;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_CTRL   = 3'd1,
        ACC_SET    = 3'd2,
        ACC_CLR    = 3'd3,
        ACC_SHADOW = 3'd4
    } acc_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/fsr_addr_decode.sv
module fsr_addr_decode
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_WORDS = 128,
    parameter int IDX_W = 7,
    parameter int STRIDE_LOG2 = 4,
    parameter logic [ADDR_W-1:0] SHADOW_BASE = 12'h400,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h000,
    parameter logic [ADDR_W-1:0] SET_OFF = 12'h004,
    parameter logic [ADDR_W-1:0] CLR_OFF = 12'h008
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS << STRIDE_LOG2);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off  = addr - SHADOW_BASE;
        idx  = off[STRIDE_LOG2 +: IDX_W];
        kind = ACC_NONE;
        if (addr == CTRL_OFF) begin
            kind = ACC_CTRL;
        end else if (addr == SET_OFF) begin
            kind = ACC_SET;
        end else if (addr == CLR_OFF) begin
            kind = ACC_CLR;
        end else if ((addr >= SHADOW_BASE) && (off < SPAN) &&
                     (off[STRIDE_LOG2-1:0] == '0)) begin
            kind = ACC_SHADOW;
        end
    end
endmodule

// File: rtl/fsr_reload_seq.sv
module fsr_reload_seq
    import fsr_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int IDX_W = 7,
    parameter int WORD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             fuse_rd,
    output logic [IDX_W-1:0] fuse_addr,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx
);
    localparam int CNT_W = (WORD_CYCLES > 1) ? $clog2(WORD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic last_word;

    always_comb begin
        s_d       = s_q;
        cap_en    = 1'b0;
        last_word = (s_q.idx == IDX_LAST);
        case (s_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.state = SEQ_RUN;
                    s_d.idx   = '0;
                    s_d.cnt   = '0;
                end
            end
            default: begin
                if (s_q.cnt == CNT_LAST) begin
                    cap_en  = 1'b1;
                    s_d.cnt = '0;
                    if (last_word) begin
                        s_d.state = SEQ_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SEQ_IDLE, idx: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state == SEQ_RUN);
    assign fuse_rd   = busy;
    assign fuse_addr = s_q.idx;
    assign cap_idx   = s_q.idx;

    // R4: the refresh only ends after the last word has been captured
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(cap_en && last_word)) |=> busy);
    // R4: fetch address climbs by one after each capture
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !last_word) |=> (fuse_addr == $past(fuse_addr) + 1'b1));
    // R4: fetch address holds between captures
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cap_en) |=> $stable(fuse_addr));
    // R4: a refresh begins at word 0
    a_r4_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fuse_addr == '0));
endmodule

// File: rtl/fsr_shadow_store.sv
module fsr_shadow_store
    import fsr_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [NUM_WORDS];
    logic [WORD_W-1:0] mem_d [NUM_WORDS];

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (cap_en && (cap_idx == IDX_W'(i))) begin
                mem_d[i] = cap_data;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                mem_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R6: a bus write and a refresh capture never compete for the store
    a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en && wr_en));
    // R5: a captured fuse word lands in its shadow
    a_r5_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (mem_q[$past(cap_idx)] == $past(cap_data)));
endmodule

// File: rtl/fsr_access_ctl.sv
module fsr_access_ctl
    import fsr_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  acc_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_locked,
    input  logic              wr_locked,
    input  logic              busy,
    input  logic [WORD_W-1:0] shadow_word,
    output logic              shadow_wr_en,
    output logic              reload_start,
    output logic              error,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              error;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } acc_t;

    acc_t a_d, a_q;
    logic [WORD_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_RELOAD_BIT] = busy;
        ctrl_word[CTRL_ERROR_BIT]  = a_q.error;
        ctrl_word[CTRL_BUSY_BIT]   = busy;
    end

    always_comb begin
        a_d          = a_q;
        a_d.rvalid   = req && !we;
        a_d.rdata    = '0;
        shadow_wr_en = 1'b0;
        reload_start = 1'b0;
        if (req) begin
            case (kind)
                ACC_CTRL: begin
                    if (!we) a_d.rdata = ctrl_word;
                end
                ACC_SET: begin
                    if (!we) begin
                        a_d.rdata = ctrl_word;
                    end else begin
                        if (wdata[CTRL_ERROR_BIT]) a_d.error = 1'b1;
                        if (wdata[CTRL_RELOAD_BIT] && !wdata[CTRL_ERROR_BIT] &&
                            !a_q.error && !busy) begin
                            reload_start = 1'b1;
                        end
                    end
                end
                ACC_CLR: begin
                    if (!we) begin
                        a_d.rdata = ctrl_word;
                    end else if (wdata[CTRL_ERROR_BIT]) begin
                        a_d.error = 1'b0;
                    end
                end
                ACC_SHADOW: begin
                    if (!a_q.error) begin
                        if (we) begin
                            if (busy || wr_locked) begin
                                a_d.error = 1'b1;
                            end else begin
                                shadow_wr_en = 1'b1;
                            end
                        end else if (rd_locked) begin
                            a_d.rdata = LOCKED_MARKER;
                            a_d.error = 1'b1;
                        end else begin
                            a_d.rdata = shadow_word;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '{error: 1'b0, rdata: '0, rvalid: 1'b0};
        end else begin
            a_q <= a_d;
        end
    end

    assign error  = a_q.error;
    assign rdata  = a_q.rdata;
    assign rvalid = a_q.rvalid;

    // R3: every read is answered on the next edge
    a_r3_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    // R6: no shadow write is let through during a refresh
    a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_wr_en |-> !busy);
    // R7: a write-locked word is never written from the bus
    a_r7_wr_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && kind == ACC_SHADOW && wr_locked) |=> error);
    // R8: locked read gives the marker and raises the flag
    a_r8_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && kind == ACC_SHADOW && rd_locked && !error)
        |=> (rdata == LOCKED_MARKER && error));
    // R9: the flag blocks shadow writes and refresh starts
    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!shadow_wr_en && !reload_start));
    // R10: a clear of bit 1 drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && kind == ACC_CLR && wdata[CTRL_ERROR_BIT]) |=> !error);
    // R11: setting the flag in the same write wins over a start
    a_r11_both_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && kind == ACC_SET && wdata[CTRL_ERROR_BIT]) |-> !reload_start);
endmodule

// File: rtl/fsr_shadow_file.sv
module fsr_shadow_file
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_WORDS = 128,
    parameter int WORD_CYCLES = 4,
    parameter int STRIDE_LOG2 = 4,
    parameter logic [ADDR_W-1:0] SHADOW_BASE = 12'h400,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_WORDS-1:0] rd_lock,
    input  logic [NUM_WORDS-1:0] wr_lock,
    output logic [IDX_W-1:0]     fuse_addr,
    output logic                 fuse_rd,
    input  logic [31:0]          fuse_data,
    output logic                 busy,
    output logic                 error
);
    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              shadow_wr_en;
    logic              reload_start;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [WORD_W-1:0] shadow_word;

    fsr_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
        .STRIDE_LOG2(STRIDE_LOG2), .SHADOW_BASE(SHADOW_BASE),
        .CTRL_OFF(ADDR_W'(0)), .SET_OFF(ADDR_W'(4)), .CLR_OFF(ADDR_W'(8))
    ) u_decode (
        .addr(bus_addr), .kind(kind), .idx(idx)
    );

    fsr_reload_seq #(
        .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .WORD_CYCLES(WORD_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(reload_start), .busy(busy),
        .fuse_rd(fuse_rd), .fuse_addr(fuse_addr),
        .cap_en(cap_en), .cap_idx(cap_idx)
    );

    fsr_shadow_store #(
        .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(fuse_data),
        .wr_en(shadow_wr_en), .wr_idx(idx), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_word(shadow_word)
    );

    fsr_access_ctl #(
        .IDX_W(IDX_W)
    ) u_access (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .kind(kind),
        .wdata(bus_wdata), .rd_locked(rd_lock[idx]), .wr_locked(wr_lock[idx]),
        .busy(busy), .shadow_word(shadow_word),
        .shadow_wr_en(shadow_wr_en), .reload_start(reload_start),
        .error(error), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    // R9: a refresh never starts while the flag is up
    a_r9_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && error) |=> !busy);
endmodule

// File: tb/tb_fsr_shadow_file.sv
`timescale 1ns/1ps
module tb_fsr_shadow_file;
    localparam int NW = 128;
    localparam int WC = 4;
    localparam int BN = NW * WC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NW-1:0] rd_lock;
    logic [NW-1:0] wr_lock;
    logic [6:0]  fuse_addr;
    logic        fuse_rd;
    logic [31:0] fuse_data;
    logic        busy;
    logic        error;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] fuse_val(input int i);
        return 32'hC0DE_0000 ^ (i * 32'h0001_0125);
    endfunction

    assign fuse_data = fuse_val(int'(fuse_addr));
    assign rd_lock = NW'(1) << 5;
    assign wr_lock = NW'(1) << 7;

    fsr_shadow_file dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rd_lock(rd_lock), .wr_lock(wr_lock),
        .fuse_addr(fuse_addr), .fuse_rd(fuse_rd), .fuse_data(fuse_data),
        .busy(busy), .error(error)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic access(input logic we_i, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we_i; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h400, 32'h1111_1111, 32'h0},          // R2 write word 0
        '{1'b0, 12'h400, 32'h0, 32'h1111_1111},          // R2 R3 read word 0
        '{1'b1, 12'h410, 32'h2222_2222, 32'h0},          // R2 write word 1
        '{1'b0, 12'h410, 32'h0, 32'h2222_2222},          // R2 read word 1
        '{1'b0, 12'h400, 32'h0, 32'h1111_1111},          // R2 word 0 intact
        '{1'b1, 12'hBF0, 32'hCAFE_F00D, 32'h0},          // R2 last word
        '{1'b0, 12'hBF0, 32'h0, 32'hCAFE_F00D},          // R2 last word back
        '{1'b0, 12'h404, 32'h0, 32'h0},                  // R2 misaligned read
        '{1'b1, 12'h408, 32'h5555_5555, 32'h0},          // R2 misaligned write
        '{1'b0, 12'h400, 32'h0, 32'h1111_1111},          // R2 no side effect
        '{1'b0, 12'hC00, 32'h0, 32'h0},                  // R2 beyond last word
        '{1'b0, 12'h000, 32'h0, 32'h0},                  // R10 ctrl idle
        '{1'b1, 12'h000, 32'h0000_0003, 32'h0},          // R10 base write
        '{1'b0, 12'h000, 32'h0, 32'h0}                   // R10 base write ignored
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 32'h0);
        chk("R1 error after reset", 32'(error), 32'h0);
        chk("R1 rvalid after reset", 32'(bus_rvalid), 32'h0);
        access(1'b0, 12'h420, '0);
        chk("R1 shadow reset value", bus_rdata, 32'h0);
        access(1'b0, 12'h000, '0);
        chk("R1 ctrl reset value", bus_rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].we, VECS[v].addr, VECS[v].wdata);
            if (!VECS[v].we) begin
                chk($sformatf("R2 vector %0d rdata", v), bus_rdata, VECS[v].exp);
                chk($sformatf("R3 vector %0d rvalid", v), 32'(bus_rvalid), 32'h1);
            end
            chk($sformatf("R2 vector %0d error", v), 32'(error), 32'h0);
        end

        // R8 read-locked word 5
        access(1'b0, 12'h450, '0);
        chk("R8 marker", bus_rdata, 32'hBADA_BADA);
        chk("R8 error set", 32'(error), 32'h1);
        // R9 accesses blocked while flagged
        access(1'b0, 12'h400, '0);
        chk("R9 read blocked", bus_rdata, 32'h0);
        access(1'b1, 12'h400, 32'h9999_9999);
        access(1'b1, 12'h004, 32'h1);
        chk("R9 reload ignored", 32'(busy), 32'h0);
        access(1'b0, 12'h000, '0);
        chk("R9 ctrl readable", bus_rdata, 32'h2);
        // R10 clear semantics
        access(1'b1, 12'h008, 32'h0);
        chk("R10 zero clear keeps flag", 32'(error), 32'h1);
        access(1'b1, 12'h008, 32'h2);
        chk("R10 clear", 32'(error), 32'h0);
        access(1'b0, 12'h400, '0);
        chk("R9 dropped write left word", bus_rdata, 32'h1111_1111);
        // R7 write-locked word 7
        access(1'b1, 12'h470, 32'h7777_7777);
        chk("R7 error set", 32'(error), 32'h1);
        access(1'b1, 12'h008, 32'h2);
        access(1'b0, 12'h470, '0);
        chk("R7 word unchanged", bus_rdata, 32'h0);
        // R10 set alias
        access(1'b1, 12'h004, 32'h2);
        chk("R10 set flag", 32'(error), 32'h1);
        access(1'b1, 12'h008, 32'h2);
        // R11 both bits
        access(1'b1, 12'h004, 32'h3);
        chk("R11 flag set", 32'(error), 32'h1);
        chk("R11 no refresh", 32'(busy), 32'h0);
        access(1'b1, 12'h008, 32'h2);

        // R4 R5 R6 refresh with accesses inside it
        access(1'b1, 12'h004, 32'h1);
        bc = 0;
        while (busy) begin
            bus_req = 1'b0; bus_we = 1'b0;
            bc++;
            chk("R4 fuse address order", 32'(fuse_addr), 32'((bc - 1) / WC));
            chk("R4 fuse_rd", 32'(fuse_rd), 32'h1);
            if (bc == 3) begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h400; bus_wdata = 32'hAAAA_0000;
            end else if (bc == 4) begin
                chk("R6 write during refresh", 32'(error), 32'h1);
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h2;
            end else if (bc == 5) begin
                chk("R10 clear during refresh", 32'(error), 32'h0);
            end else if (bc == 10) begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h1;
            end else if (bc == 20) begin
                bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
            end else if (bc == 21) begin
                chk("R4 ctrl bits during refresh", bus_rdata, 32'h5);
            end else if (bc == BN) begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h420; bus_wdata = 32'h1234_5678;
            end
            @(negedge clk);
            if (bc > BN + 4) break;
        end
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R4 refresh length", 32'(bc), 32'(BN));
        chk("R6 last-cycle write flagged", 32'(error), 32'h1);
        access(1'b1, 12'h008, 32'h2);
        for (int i = 0; i < NW; i++) begin
            if (i != 5) begin
                access(1'b0, 12'(12'h400 + (i << 4)), '0);
                chk($sformatf("R5 word %0d after refresh", i), bus_rdata, fuse_val(i));
            end
        end
        chk("R5 no spurious error", 32'(error), 32'h0);
        access(1'b0, 12'h000, '0);
        chk("R4 ctrl idle after refresh", bus_rdata, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule